// File: doc/BRIEF.md
# Receive FIFO with Hysteretic RTS Flow Control

This block sits behind a UART receiver. Each received character arrives as 8 data bits with a 3-bit error tag and is stored in a 64-entry first-in first-out buffer. The host drains the buffer through a pop port. The oldest entry is always visible at that port, so it can be read before the pop. A selectable receive threshold raises a level interrupt when the buffer holds at least that many characters.

The block also drives the active-low RTS# line, which tells the remote transmitter to pause or resume. When automatic flow control is enabled, RTS# goes high (pause) once the fill level reaches the threshold one table step above the selected one. It goes low again (resume) only after the fill level falls to the threshold one step below. Between those two points it keeps its last value. Software keeps overall control through a request bit: clearing the request always forces RTS# high. An optional status flag records every rising edge of RTS#. Characters that arrive after a pause request are still stored until the buffer is full. A character that arrives when the buffer is full is dropped and raises a sticky overrun flag.

Top module: `rx_fifo_rts`

## Requirements
- R1: Popped entries leave in the order they were pushed. `popData`/`popErr` always show the oldest stored entry, with its 8 data bits and 3 error-tag bits kept together.
- R2: `count` gives the number of stored entries, from 0 to 64, and `empty` is high exactly when it is 0. A cycle with both an accepted push and an accepted pop leaves the count unchanged. A pop while the buffer is empty has no effect.
- R3: A push while the buffer holds 64 entries is dropped and sets `overrun` on the next cycle. `overrun` stays set until a cycle with `statusRd` high and no new overrun.
- R4: `trigSel` encodes the receive threshold: 0 means 8, 1 means 16, 2 means 56 and 3 means 60. `rxTrigIrq` is high whenever `count` is at or above the selected threshold.
- R5: With `autoRtsEn` and `rtsReq` both high, `rtsN` goes high one cycle after `count` reaches the pause level: 16, 56, 60 and 60 for selections 0 to 3. It goes low one cycle after `count` falls to the resume level: 0, 8, 16 and 56 for selections 0 to 3.
- R6: With automatic flow control active, `rtsN` keeps its previous value while `count` lies strictly between the resume and pause levels.
- R7: `rtsReq` low forces `rtsN` high one cycle later. `rtsReq` high with `autoRtsEn` low drives `rtsN` low one cycle later.
- R8: When `rtsIntEn` is high on the cycle in which `rtsN` changes from low to high, `rtsIntFlag` is set. The flag stays set until a cycle with `intStatRd` high and no new rising edge. No rising edge sets it while `rtsIntEn` is low.
- R9: A synchronous reset (`rst` high) empties the buffer, drives `rtsN` high and clears `overrun` and `rtsIntFlag`.
- R10: After `rtsN` has gone high, received characters are still accepted until the count reaches 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | Received character present this cycle |
| rxData | input | 8 | Received character |
| rxErr | input | 3 | Error tag of the received character |
| popReq | input | 1 | Remove the oldest entry |
| popData | output | 8 | Data of the oldest entry |
| popErr | output | 3 | Error tag of the oldest entry |
| trigSel | input | 2 | Receive threshold selection |
| autoRtsEn | input | 1 | Automatic flow control enable |
| rtsReq | input | 1 | Software RTS request |
| rtsIntEn | input | 1 | Enables the RTS rising-edge flag |
| statusRd | input | 1 | Status read strobe; clears overrun |
| intStatRd | input | 1 | Interrupt-status read strobe; clears the RTS flag |
| rtsN | output | 1 | Active-low RTS line |
| rxTrigIrq | output | 1 | Receive threshold interrupt |
| rtsIntFlag | output | 1 | Sticky RTS rising-edge flag |
| overrun | output | 1 | Sticky overrun flag |
| count | output | 7 | Number of stored entries |
| empty | output | 1 | Buffer empty |

## Verification
The bench builds the block with its default parameters: a depth of 64, 8 data bits, 3 tag bits and the thresholds 8, 16, 56 and 60. With these values the buffer can be filled to its limit, so the overrun path is reachable. Every threshold selection can drive the fill level past its pause level and back down below its resume level. Directed fill and drain passes walk each selection across both edges of its band. Long random stretches then mix pushes, pops, selection changes, request changes and read strobes, so that edges happen inside the hysteresis band and while the buffer is full.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic pushEn;
    logic popEn;
  } rxf_strobe_t;
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  parameter int EW = 3,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  rxf_strobe_t   strb,
  input  logic [DW-1:0] wrData,
  input  logic [EW-1:0] wrErr,
  output logic [DW-1:0] rdData,
  output logic [EW-1:0] rdErr,
  output logic [CW-1:0] count
);
  localparam int EntryW = DW + EW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EntryW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.pushEn) store[wrPtr] <= {wrErr, wrData};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.pushEn) wrPtr <= nextPtr(wrPtr);
      if (strb.popEn) rdPtr <= nextPtr(rdPtr);
      case ({strb.pushEn, strb.popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign {rdErr, rdData} = store[rdPtr];
endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL0 = 8,
  parameter int LVL1 = 16,
  parameter int LVL2 = 56,
  parameter int LVL3 = 60,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxValid,
  input  logic          popReq,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trigSel,
  input  logic          autoRtsEn,
  input  logic          rtsReq,
  input  logic          rtsIntEn,
  input  logic          statusRd,
  input  logic          intStatRd,
  output rxf_strobe_t   strb,
  output logic          rtsN,
  output logic          rxTrigIrq,
  output logic          rtsIntFlag,
  output logic          overrun
);
  logic full, isEmpty;
  logic [CW-1:0] trigLvl, pauseLvl, resumeLvl;
  logic stopped, stoppedNext, rtsNNext;

  assign full    = (count == CW'(DEPTH));
  assign isEmpty = (count == '0);

  assign strb.pushEn = rxValid & ~full;
  assign strb.popEn  = popReq & ~isEmpty;

  always_comb begin
    case (trigSel)
      2'd0: begin trigLvl = CW'(LVL0); pauseLvl = CW'(LVL1); resumeLvl = '0;        end
      2'd1: begin trigLvl = CW'(LVL1); pauseLvl = CW'(LVL2); resumeLvl = CW'(LVL0); end
      2'd2: begin trigLvl = CW'(LVL2); pauseLvl = CW'(LVL3); resumeLvl = CW'(LVL1); end
      default: begin trigLvl = CW'(LVL3); pauseLvl = CW'(LVL3); resumeLvl = CW'(LVL2); end
    endcase
  end

  assign rxTrigIrq = (count >= trigLvl);

  always_comb begin
    if (!(rtsReq && autoRtsEn))  stoppedNext = 1'b0;
    else if (count >= pauseLvl)  stoppedNext = 1'b1;
    else if (count <= resumeLvl) stoppedNext = 1'b0;
    else                         stoppedNext = stopped;
  end

  assign rtsNNext = ~rtsReq | (autoRtsEn & stoppedNext);

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped    <= 1'b0;
      rtsN       <= 1'b1;
      rtsIntFlag <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      stopped <= stoppedNext;
      rtsN    <= rtsNNext;
      if (rtsIntEn && !rtsN && rtsNNext) rtsIntFlag <= 1'b1;
      else if (intStatRd)                rtsIntFlag <= 1'b0;
      if (rxValid && full)  overrun <= 1'b1;
      else if (statusRd)    overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  parameter int EW = 3,
  parameter int LVL0 = 8,
  parameter int LVL1 = 16,
  parameter int LVL2 = 56,
  parameter int LVL3 = 60
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rxValid,
  input  logic [DW-1:0]                rxData,
  input  logic [EW-1:0]                rxErr,
  input  logic                         popReq,
  output logic [DW-1:0]                popData,
  output logic [EW-1:0]                popErr,
  input  logic [1:0]                   trigSel,
  input  logic                         autoRtsEn,
  input  logic                         rtsReq,
  input  logic                         rtsIntEn,
  input  logic                         statusRd,
  input  logic                         intStatRd,
  output logic                         rtsN,
  output logic                         rxTrigIrq,
  output logic                         rtsIntFlag,
  output logic                         overrun,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int CW = $clog2(DEPTH + 1);

  rxf_strobe_t strb;

  rxf_control #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .popReq(popReq), .count(count),
    .trigSel(trigSel), .autoRtsEn(autoRtsEn), .rtsReq(rtsReq), .rtsIntEn(rtsIntEn),
    .statusRd(statusRd), .intStatRd(intStatRd), .strb(strb), .rtsN(rtsN),
    .rxTrigIrq(rxTrigIrq), .rtsIntFlag(rtsIntFlag), .overrun(overrun)
  );

  rxf_datapath #(.DEPTH(DEPTH), .DW(DW), .EW(EW), .CW(CW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(rxData), .wrErr(rxErr),
    .rdData(popData), .rdErr(popErr), .count(count)
  );

  assign empty = (count == '0);
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rxValid,
  input logic                       popReq,
  input logic                       rtsReq,
  input logic                       rtsIntEn,
  input logic                       rtsN,
  input logic                       rtsIntFlag,
  input logic                       overrun,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       empty
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)) else $error("count above depth"); // R2

  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
    (empty && popReq && !rxValid) |=> empty) else $error("pop on empty changed state"); // R2

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (rxValid && count == CW'(DEPTH)) |=> overrun) else $error("overrun not set"); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !popReq) |=> count == CW'(DEPTH)) else $error("full count moved"); // R10

  AST_RTS_FORCED: assert property (@(posedge clk) disable iff (rst)
    !rtsReq |=> rtsN) else $error("rtsN low without request"); // R7

  AST_RTS_INT_SET: assert property (@(posedge clk) disable iff (rst)
    ($rose(rtsN) && $past(rtsIntEn)) |-> rtsIntFlag) else $error("rts flag missed"); // R8
endmodule

bind rx_fifo_rts rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
  .clk(clk), .rst(rst), .rxValid(rxValid), .popReq(popReq), .rtsReq(rtsReq),
  .rtsIntEn(rtsIntEn), .rtsN(rtsN), .rtsIntFlag(rtsIntFlag), .overrun(overrun),
  .count(count), .empty(empty)
);

// File: tb/rx_fifo_rts_bench.sv
module rx_fifo_rts_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxValid = 1'b0, popReq = 1'b0;
  logic [7:0] rxData = '0;
  logic [2:0] rxErr = '0;
  logic [1:0] trigSel = '0;
  logic autoRtsEn = 1'b0, rtsReq = 1'b0, rtsIntEn = 1'b0, statusRd = 1'b0, intStatRd = 1'b0;
  logic [7:0] popData;
  logic [2:0] popErr;
  logic rtsN, rxTrigIrq, rtsIntFlag, overrun, empty;
  logic [6:0] count;

  rx_fifo_rts u_rx_fifo_rts (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [10:0] q[$];
  bit mStop, mRts = 1'b1, mFlag, mOvr, started;
  int nChecks = 0, nFail = 0;
  string phase = "R9 reset";
  bit done = 1'b0;

  function automatic int lvl(input int s);
    case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
  endfunction

  always @(posedge clk) begin
    int c, pause, resume;
    bit stopN, rtsNext;
    started <= 1'b1;
    if (rst) begin
      q.delete(); mStop = 0; mRts = 1; mFlag = 0; mOvr = 0;
    end else begin
      c = q.size();
      pause  = (trigSel == 3) ? 60 : lvl(trigSel + 1);
      resume = (trigSel == 0) ? 0 : lvl(trigSel - 1);
      if (!(rtsReq && autoRtsEn)) stopN = 0;
      else if (c >= pause)        stopN = 1;
      else if (c <= resume)       stopN = 0;
      else                        stopN = mStop;
      rtsNext = !rtsReq || (autoRtsEn && stopN);
      if (rtsIntEn && !mRts && rtsNext) mFlag = 1;
      else if (intStatRd)               mFlag = 0;
      if (rxValid && c == DEPTH) mOvr = 1;
      else if (statusRd)         mOvr = 0;
      mStop = stopN; mRts = rtsNext;
      if (popReq && c > 0) void'(q.pop_front());
      if (rxValid && c < DEPTH) q.push_back({rxErr, rxData});
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s [%s] at %0t: actual %0h expected %0h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 count", count, q.size());
      chk("R2 empty", empty, q.size() == 0);
      if (q.size() > 0) chk("R1 head", {popErr, popData}, q[0]);
      chk("R4 trigger", rxTrigIrq, q.size() >= lvl(trigSel));
      chk("R5 R6 R7 rtsN", rtsN, mRts);
      chk("R8 rts flag", rtsIntFlag, mFlag);
      chk("R3 overrun", overrun, mOvr);
    end
  end

  task automatic step(input bit push, input bit pop);
    @(posedge clk); #1;
    rxValid = push; popReq = pop;
    rxData = 8'($urandom); rxErr = 3'($urandom);
    statusRd = 1'b0; intStatRd = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) step(0, 0);
    rst = 1'b0;
    // R7: request off, then manual request with auto disabled
    phase = "R7 manual";
    repeat (3) step(1, 0);
    rtsReq = 1'b1;
    repeat (3) step(0, 1);
    rtsReq = 1'b0;
    repeat (2) step(0, 0);
    // R10 / R3: fill past full with auto flow control on
    phase = "R10 R3 fill";
    rtsReq = 1'b1; autoRtsEn = 1'b1; rtsIntEn = 1'b1; trigSel = 2'd0;
    repeat (75) step(1, 0);
    step(0, 0); intStatRd = 1'b1;
    step(0, 0); statusRd = 1'b1;
    step(0, 0);
    phase = "R5 R6 drain";
    repeat (70) step(0, 1);
    // each threshold selection across its band
    for (int s = 0; s < 4; s++) begin
      phase = "R4 R5 R6 sweep";
      trigSel = 2'(s);
      rtsIntEn = s[0];
      repeat (66) step(1, 0);
      repeat (66) step(0, 1);
      repeat (300) step($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 45);
      step(0, 0); intStatRd = 1'b1;
    end
    // R2: simultaneous push and pop
    phase = "R2 simultaneous";
    repeat (10) step(1, 0);
    repeat (20) step(1, 1);
    repeat (12) step(0, 1);
    repeat (3) step(0, 1);
    // random mix of everything
    phase = "R1 R3 R6 R8 random";
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 99) < 52, $urandom_range(0, 99) < 48);
      if ($urandom_range(0, 99) < 2) trigSel = 2'($urandom);
      if ($urandom_range(0, 99) < 1) rtsReq = ~rtsReq;
      if ($urandom_range(0, 99) < 1) autoRtsEn = ~autoRtsEn;
      if ($urandom_range(0, 99) < 2) rtsIntEn = ~rtsIntEn;
      statusRd = ($urandom_range(0, 99) < 3);
      intStatRd = ($urandom_range(0, 99) < 3);
    end
    // R9: reset from a loaded state
    phase = "R9 reset";
    rtsReq = 1'b1; autoRtsEn = 1'b0;
    repeat (20) step(1, 0);
    rst = 1'b1;
    repeat (2) step(0, 0);
    rst = 1'b0;
    repeat (3) step(0, 0);
    summary();
  end
endmodule